// File: doc/BRIEF.md
# Audio Codec Register File

This block models the control register space of a stereo audio codec. The space is 64 registers of 16 bits each. A controller reaches it through one 32-bit command port. Each command word carries four fields: a codec select, a read/write flag, a register index and 16 bits of write data. The block registers the accepted command into a status word that software reads back. After a read, that word holds the addressed register's contents and a data-valid flag.

Several registers do more than store what is written:

- **Register 0x00:** any write to it returns the whole space to its power-on image.
- **Volume registers:** mute bits force attenuation fields to all ones, and reserved bits are masked off.
- **Rate registers:** written rates snap to the nearest supported sample rate. This happens only while variable-rate mode is enabled.
- **Identity registers:** they never change.

The block also produces live playback controls from the master and PCM-out volume registers. These are an 8-bit gain per channel, formed from the two cascaded attenuations, and a combined mute flag.

Top module: `audio_codec_regs`

## Requirements
- R1: A command whose codec select (bits 31:30) is nonzero is discarded. No register changes, and the status word is left unchanged.
- R2: A read command (bit 23 = 1) takes its index from bits 22:16. One cycle later the status word is (cmd & 0xC0FF0000) | (1 << 25) | contents of the indexed register.
- R3: A write command (bit 23 = 0) leaves the status word equal to cmd & 0xC0FFFFFF, so bit 25 is clear.
- R4: Each register has a power-on value:
  - 0x00 = 0x6A90
  - 0x02, 0x04 and 0x06 = 0x8000
  - 0x0C and 0x0E = 0x8008
  - 0x10, 0x12, 0x14, 0x16 and 0x18 = 0x8808
  - 0x1C = 0x8000
  - 0x26 = 0x000F
  - 0x28 = 0x0A05
  - 0x2A = 0x0400
  - 0x2C and 0x32 = 48000
  - 0x7C = 0x8384
  - 0x7E = 0x7666
  - every other register = 0
  - the status word = 0
- R5: Any write to register 0x00 restores every register to its R4 value.
- R6: Writes to master volume (0x02) are modified before storage:
  - if bit 13 is set, bits 12:8 become 0x1F;
  - if bit 5 is set, bits 4:0 become 0x1F;
  - the result is then masked with 0x9F1F.
  PCM-out (0x18) is masked with 0x9F1F and gets no forcing.
- R7: In extended control (0x2A), only bit 0 (variable-rate enable) is writable. Writing it as 0 also sets 0x2C and 0x32 to 48000.
- R8: Writes to 0x2C or 0x32 are ignored while bit 0 of 0x2A is 0.
- R9: With variable rate enabled, an unsigned rate value v is stored as follows:
  - 8000 if v < 9512
  - 11025 if v < 13512
  - 16000 if v < 19025
  - 22050 if v < 27025
  - 32000 if v < 38050
  - 44100 if v < 46050
  - 48000 otherwise
- R10: A write to powerdown (0x26) updates only bits 15:8 and keeps bits 7:0.
- R11: Writes to 0x28, 0x7C and 0x7E are ignored.
- R12: All other registers store the written value. Index bit 16 is ignored, so 0x41 addresses the same register as 0x40.
- R13: Each channel's gain is (255 − ⌊255·m/31⌋)·(255 − ⌊255·p/31⌋)/255, truncated. Here m is the master attenuation field and p the PCM-out attenuation field. The left channel uses bits 12:8 and the right channel uses bits 4:0. The gain follows register state in the same cycle the register updates.
- R14: The mute output is 1 whenever bit 15 of master or of PCM-out is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command strobe, one command per cycle |
| cmd_wdata | input | 32 | Command word |
| cmd_rdata | output | 32 | Registered status word |
| play_gain_l | output | 8 | Left playback gain |
| play_gain_r | output | 8 | Right playback gain |
| play_mute | output | 1 | Playback mute |

## Verification
The assertions check the following on every cycle:
- the status word obeys the read and write formats;
- a discarded command leaves all state frozen;
- the rate registers only ever hold a supported rate;
- rate writes are locked out while variable rate is off;
- master mute forcing is applied;
- the gain stage gives full scale and silence at its extreme inputs.

Only the bench scenarios show the following:
- the exact snap boundaries on either side of each midpoint;
- the partial write masks and the read-only identity registers;
- the aliasing of index bit 0;
- the full reset image, both at power-on and after a write to register 0x00;
- gain values at intermediate attenuations.

// File: rtl/acr_pkg.sv
package acr_pkg;
    localparam int CMD_W  = 32;
    localparam int DATA_W = 16;
    localparam int IDX_W  = 7;
    localparam int WIDX_W = IDX_W - 1;
    localparam int NREG   = 1 << WIDX_W;
    localparam int NRATE  = 7;

    typedef logic [NREG-1:0][DATA_W-1:0] regimg_t;

    // word indices (byte index / 2)
    localparam logic [WIDX_W-1:0] W_RESET   = 6'h00;
    localparam logic [WIDX_W-1:0] W_MASTER  = 6'h01;
    localparam logic [WIDX_W-1:0] W_HPHONE  = 6'h02;
    localparam logic [WIDX_W-1:0] W_MONO    = 6'h03;
    localparam logic [WIDX_W-1:0] W_PHONE   = 6'h06;
    localparam logic [WIDX_W-1:0] W_MIC     = 6'h07;
    localparam logic [WIDX_W-1:0] W_LINE    = 6'h08;
    localparam logic [WIDX_W-1:0] W_CD      = 6'h09;
    localparam logic [WIDX_W-1:0] W_VIDEO   = 6'h0A;
    localparam logic [WIDX_W-1:0] W_AUX     = 6'h0B;
    localparam logic [WIDX_W-1:0] W_PCMOUT  = 6'h0C;
    localparam logic [WIDX_W-1:0] W_RECGAIN = 6'h0E;
    localparam logic [WIDX_W-1:0] W_PWRDN   = 6'h13;
    localparam logic [WIDX_W-1:0] W_EXTID   = 6'h14;
    localparam logic [WIDX_W-1:0] W_EXTCTL  = 6'h15;
    localparam logic [WIDX_W-1:0] W_DACRATE = 6'h16;
    localparam logic [WIDX_W-1:0] W_ADCRATE = 6'h19;
    localparam logic [WIDX_W-1:0] W_VID1    = 6'h3E;
    localparam logic [WIDX_W-1:0] W_VID2    = 6'h3F;

    localparam logic [DATA_W-1:0] VOL_MASK = 16'h9F1F;
    localparam logic [DATA_W-1:0] RATE_TOP = 16'd48000;
    localparam logic [CMD_W-1:0]  RD_KEEP  = 32'hC0FF_0000;
    localparam logic [CMD_W-1:0]  WR_KEEP  = 32'hC0FF_FFFF;
    localparam int                VALID_BIT = 25;

    function automatic logic [DATA_W-1:0] rate_at(input int i);
        case (i)
            0:       return 16'd8000;
            1:       return 16'd11025;
            2:       return 16'd16000;
            3:       return 16'd22050;
            4:       return 16'd32000;
            5:       return 16'd44100;
            default: return 16'd48000;
        endcase
    endfunction

    function automatic logic rate_legal(input logic [DATA_W-1:0] v);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < NRATE; i++) if (v == rate_at(i)) hit = 1'b1;
        return hit;
    endfunction

    function automatic regimg_t reset_image();
        regimg_t img;
        img = '0;
        img[W_RESET]   = 16'h6A90;
        img[W_MASTER]  = 16'h8000;
        img[W_HPHONE]  = 16'h8000;
        img[W_MONO]    = 16'h8000;
        img[W_PHONE]   = 16'h8008;
        img[W_MIC]     = 16'h8008;
        img[W_LINE]    = 16'h8808;
        img[W_CD]      = 16'h8808;
        img[W_VIDEO]   = 16'h8808;
        img[W_AUX]     = 16'h8808;
        img[W_PCMOUT]  = 16'h8808;
        img[W_RECGAIN] = 16'h8000;
        img[W_PWRDN]   = 16'h000F;
        img[W_EXTID]   = 16'h0A05;
        img[W_EXTCTL]  = 16'h0400;
        img[W_DACRATE] = RATE_TOP;
        img[W_ADCRATE] = RATE_TOP;
        img[W_VID1]    = 16'h8384;
        img[W_VID2]    = 16'h7666;
        return img;
    endfunction
endpackage

// File: rtl/acr_rate_snap.sv
module acr_rate_snap
    import acr_pkg::*;
(
    input  logic [DATA_W-1:0] raw_i,
    output logic [DATA_W-1:0] snap_o
);
    // Walk from the highest midpoint down so the lowest matching entry wins (R9)
    always_comb begin
        snap_o = rate_at(NRATE - 1);
        for (int i = NRATE - 2; i >= 0; i--) begin
            if (raw_i < rate_at(i) + (rate_at(i + 1) - rate_at(i)) / 2)
                snap_o = rate_at(i);
        end
    end
endmodule

// File: rtl/acr_gain_calc.sv
module acr_gain_calc #(
    parameter int FIELD_W = 5,
    parameter int GAIN_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] master_att_i,
    input  logic [FIELD_W-1:0] pcm_att_i,
    output logic [GAIN_W-1:0]  gain_o
);
    localparam int PW = 2 * GAIN_W + FIELD_W;
    localparam logic [PW-1:0] FULL = PW'((1 << GAIN_W) - 1);
    localparam logic [PW-1:0] FMAX = PW'((1 << FIELD_W) - 1);

    logic [PW-1:0] lvl_m, lvl_p;

    // Each stage turns attenuation into a linear level; the two cascade (R13)
    always_comb begin
        lvl_m  = FULL - (FULL * PW'(master_att_i)) / FMAX;
        lvl_p  = FULL - (FULL * PW'(pcm_att_i)) / FMAX;
        gain_o = GAIN_W'((lvl_m * lvl_p) / FULL);
    end

    p_full_scale_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (master_att_i == '0 && pcm_att_i == '0) |-> gain_o == GAIN_W'(FULL));
    p_silent_at_max_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (master_att_i == FIELD_W'(FMAX)) |-> gain_o == '0);
endmodule

// File: rtl/acr_regfile.sv
module acr_regfile
    import acr_pkg::*;
#(
    parameter int FIELD_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [CMD_W-1:0]     cmd_wdata,
    input  logic [DATA_W-1:0]    snapped_rate,
    output logic [CMD_W-1:0]     cmd_rdata,
    output logic [2*FIELD_W-1:0] master_att,
    output logic [2*FIELD_W-1:0] pcm_att,
    output logic                 mute_o
);
    typedef struct packed {
        regimg_t          regs;
        logic [CMD_W-1:0] cmd;
    } st_t;

    st_t st_d, st_q;

    logic [1:0]        sel;
    logic              is_rd;
    logic [WIDX_W-1:0] widx;
    logic [DATA_W-1:0] wval;
    logic [DATA_W-1:0] mval;
    logic              take;

    always_comb begin
        sel   = cmd_wdata[31:30];
        is_rd = cmd_wdata[23];
        widx  = cmd_wdata[22:17];
        wval  = cmd_wdata[15:0];
        take  = cmd_wr && (sel == 2'b00);
        mval  = wval;
        if (wval[13]) mval[12:8] = '1;
        if (wval[5])  mval[4:0]  = '1;

        st_d = st_q;
        if (take) begin
            if (is_rd) begin
                st_d.cmd = (cmd_wdata & RD_KEEP) | (CMD_W'(1) << VALID_BIT)
                         | CMD_W'(st_q.regs[widx]);
            end else begin
                st_d.cmd = cmd_wdata & WR_KEEP;
                case (widx)
                    W_RESET:  st_d.regs = reset_image();
                    W_MASTER: st_d.regs[widx] = mval & VOL_MASK;
                    W_PCMOUT: st_d.regs[widx] = wval & VOL_MASK;
                    W_EXTCTL: begin
                        st_d.regs[widx][0] = wval[0];
                        if (!wval[0]) begin
                            st_d.regs[W_DACRATE] = RATE_TOP;
                            st_d.regs[W_ADCRATE] = RATE_TOP;
                        end
                    end
                    W_DACRATE, W_ADCRATE: begin
                        if (st_q.regs[W_EXTCTL][0]) st_d.regs[widx] = snapped_rate;
                    end
                    W_PWRDN:  st_d.regs[widx][15:8] = wval[15:8];
                    W_EXTID, W_VID1, W_VID2: ;
                    default:  st_d.regs[widx] = wval;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.regs <= reset_image();
            st_q.cmd  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_rdata  = st_q.cmd;
    assign master_att = {st_q.regs[W_MASTER][12:8], st_q.regs[W_MASTER][4:0]};
    assign pcm_att    = {st_q.regs[W_PCMOUT][12:8], st_q.regs[W_PCMOUT][4:0]};
    assign mute_o     = st_q.regs[W_MASTER][15] | st_q.regs[W_PCMOUT][15];

    p_sel_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[31:30] != 2'b00) |=> ($stable(st_q.cmd) && $stable(st_q.regs)));
    p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[31:30] == 2'b00 && cmd_wdata[23])
        |=> (cmd_rdata[VALID_BIT] && cmd_rdata[23:16] == $past(cmd_wdata[23:16])));
    p_write_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[31:30] == 2'b00 && !cmd_wdata[23])
        |=> cmd_rdata == $past(cmd_wdata & WR_KEEP));
    p_master_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[31:30] == 2'b00 && !cmd_wdata[23]
         && cmd_wdata[22:17] == W_MASTER && cmd_wdata[13])
        |=> master_att[2*FIELD_W-1:FIELD_W] == '1);
    p_rate_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_wdata[31:30] == 2'b00 && !cmd_wdata[23]
         && cmd_wdata[22:17] == W_DACRATE && !st_q.regs[W_EXTCTL][0])
        |=> $stable(st_q.regs[W_DACRATE]));
    p_rate_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rate_legal(st_q.regs[W_DACRATE]) && rate_legal(st_q.regs[W_ADCRATE]));
endmodule

// File: rtl/audio_codec_regs.sv
module audio_codec_regs
    import acr_pkg::*;
#(
    parameter int FIELD_W = 5,
    parameter int GAIN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    output logic [CMD_W-1:0]  cmd_rdata,
    output logic [GAIN_W-1:0] play_gain_l,
    output logic [GAIN_W-1:0] play_gain_r,
    output logic              play_mute
);
    logic [DATA_W-1:0]    snapped;
    logic [2*FIELD_W-1:0] master_att, pcm_att;
    logic [1:0][GAIN_W-1:0] gains;

    acr_rate_snap u_snap (
        .raw_i (cmd_wdata[15:0]),
        .snap_o(snapped)
    );

    acr_regfile #(.FIELD_W(FIELD_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_wdata   (cmd_wdata),
        .snapped_rate(snapped),
        .cmd_rdata   (cmd_rdata),
        .master_att  (master_att),
        .pcm_att     (pcm_att),
        .mute_o      (play_mute)
    );

    // channel 1 = left (upper field), channel 0 = right (lower field)
    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        acr_gain_calc #(.FIELD_W(FIELD_W), .GAIN_W(GAIN_W)) u_gain (
            .clk         (clk),
            .rst_n       (rst_n),
            .master_att_i(master_att[ch*FIELD_W +: FIELD_W]),
            .pcm_att_i   (pcm_att[ch*FIELD_W +: FIELD_W]),
            .gain_o      (gains[ch])
        );
    end

    assign play_gain_l = gains[1];
    assign play_gain_r = gains[0];
endmodule

// File: tb/sim_audio_codec_regs.sv
module sim_audio_codec_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic [7:0]  play_gain_l, play_gain_r;
    logic        play_mute;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    audio_codec_regs u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .play_gain_l(play_gain_l),
        .play_gain_r(play_gain_r), .play_mute(play_mute)
    );

    // {byte index, write data, expected readback, requirement number}
    localparam int NV = 22;
    localparam logic [47:0] VEC [NV] = '{
        {8'h2A, 16'hFFFF, 16'h0401, 8'd7},   // R7 only enable bit lands
        {8'h2C, 16'd9511, 16'd8000, 8'd9},   // R9 below first midpoint
        {8'h2C, 16'd9512, 16'd11025, 8'd9},
        {8'h2C, 16'd13511, 16'd11025, 8'd9},
        {8'h32, 16'd19025, 16'd22050, 8'd9},
        {8'h2C, 16'd27024, 16'd22050, 8'd9},
        {8'h2C, 16'd38050, 16'd44100, 8'd9},
        {8'h2C, 16'd46049, 16'd44100, 8'd9},
        {8'h2C, 16'd46050, 16'd48000, 8'd9},
        {8'h32, 16'hFFFF, 16'd48000, 8'd9},
        {8'h2C, 16'd0, 16'd8000, 8'd9},
        {8'h02, 16'h2020, 16'h1F1F, 8'd6},   // R6 forcing
        {8'h02, 16'h8A05, 16'h8A05, 8'd6},
        {8'h18, 16'hFFFF, 16'h9F1F, 8'd6},   // PCM-out mask only
        {8'h18, 16'h2020, 16'h0000, 8'd6},   // no forcing on PCM-out
        {8'h26, 16'h12AB, 16'h120F, 8'd10},  // R10
        {8'h28, 16'h1234, 16'h0A05, 8'd11},  // R11
        {8'h7C, 16'h0000, 16'h8384, 8'd11},
        {8'h40, 16'hBEEF, 16'hBEEF, 8'd12},  // R12
        {8'h2A, 16'h0000, 16'h0400, 8'd7},   // R7 disable
        {8'h2C, 16'd8000, 16'd48000, 8'd8},  // R8 locked, forced 48000 held
        {8'h32, 16'd16000, 16'd48000, 8'd8}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_wr = 1'b0;
        cmd_wdata = '0;
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        do_cmd({8'h00, 1'b0, a, d});
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] v);
        do_cmd({8'h00, 1'b1, a, 16'h0000});
        v = cmd_rdata[15:0];
    endtask

    function automatic int gain_of(input int m, input int p);
        int a, b;
        a = 255 - (255 * m) / 31;
        b = 255 - (255 * p) / 31;
        return (a * b) / 255;
    endfunction

    task automatic chk_gain(input logic [15:0] mv, input logic [15:0] pv);
        wr(7'h02, mv);
        wr(7'h18, pv);
        chk("R13 left", {24'h0, play_gain_l}, 32'(gain_of(int'(mv[12:8]), int'(pv[12:8]))));
        chk("R13 right", {24'h0, play_gain_r}, 32'(gain_of(int'(mv[4:0]), int'(pv[4:0]))));
        chk("R14 mute", {31'h0, play_mute}, {31'h0, mv[15] | pv[15]});
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 power-on image
        chk("R4 status", cmd_rdata, 32'h0);
        chk("R4 gain l", {24'h0, play_gain_l}, 32'(gain_of(0, 8)));
        chk("R4 gain r", {24'h0, play_gain_r}, 32'(gain_of(0, 8)));
        chk("R4 mute", {31'h0, play_mute}, 32'h1);
        rd(7'h00, v); chk("R4 reg00", {16'h0, v}, 32'h6A90);
        rd(7'h0C, v); chk("R4 reg0C", {16'h0, v}, 32'h8008);
        rd(7'h16, v); chk("R4 reg16", {16'h0, v}, 32'h8808);
        rd(7'h26, v); chk("R4 reg26", {16'h0, v}, 32'h000F);
        rd(7'h2C, v); chk("R4 reg2C", {16'h0, v}, 32'd48000);
        rd(7'h7E, v); chk("R4 reg7E", {16'h0, v}, 32'h7666);
        rd(7'h40, v); chk("R4 reg40", {16'h0, v}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][46:40], VEC[i][39:24]);
            rd(VEC[i][46:40], v);
            checks++;
            if (v !== VEC[i][23:8]) begin
                fails++;
                $display("FAIL R%0d row %0d actual=%h expected=%h", VEC[i][7:0], i, v, VEC[i][23:8]);
            end
        end

        // R12 index bit 0 aliases
        wr(7'h41, 16'h1357);
        rd(7'h40, v); chk("R12 alias", {16'h0, v}, 32'h1357);

        // R3 write status format
        do_cmd(32'h3F42_BEEF);
        chk("R3 write status", cmd_rdata, 32'h0042_BEEF);
        // R2 read status format, junk in low half
        do_cmd(32'h3FC2_1234);
        chk("R2 read status", cmd_rdata, 32'h02C2_BEEF);
        do_cmd(32'h00FE_5555);
        chk("R2 read id", cmd_rdata, 32'h02FE_7666);

        // R1 nonzero codec select discarded
        do_cmd(32'h4042_0000);
        chk("R1 status held", cmd_rdata, 32'h02FE_7666);
        do_cmd(32'hC0C2_0000);
        chk("R1 read ignored", cmd_rdata, 32'h02FE_7666);
        rd(7'h42, v); chk("R1 reg kept", {16'h0, v}, 32'hBEEF);

        // R13 / R14 gain and mute
        chk_gain(16'h0000, 16'h0000);
        chk_gain(16'h0310, 16'h0701);
        chk_gain(16'h1F00, 16'h001F);
        chk_gain(16'h0A05, 16'h8C0E);
        chk_gain(16'h8000, 16'h0000);

        // R5 reset through register 0x00
        wr(7'h40, 16'hA5A5);
        wr(7'h00, 16'h0000);
        rd(7'h02, v); chk("R5 master", {16'h0, v}, 32'h8000);
        rd(7'h18, v); chk("R5 pcm", {16'h0, v}, 32'h8808);
        rd(7'h2A, v); chk("R5 extctl", {16'h0, v}, 32'h0400);
        rd(7'h40, v); chk("R5 plain", {16'h0, v}, 32'h0);
        rd(7'h42, v); chk("R5 plain2", {16'h0, v}, 32'h0);
        chk("R5 mute", {31'h0, play_mute}, 32'h1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule